// File: doc/BRIEF.md
# Pixel Column Frame Formatter

This block sits between the derandomizing buffers of one pixel column and the output buffer that feeds a serial link. Every hit it accepts carries a column address, a pixel index, a coarse timestamp and a fine timestamp. The block packs each hit into one 32-bit word and passes it on through a one-word output register with a valid/ready handshake.

Output words are grouped into frames. A frame ends each time the free-running coarse counter completes a turn, which the block learns from a single-cycle wrap pulse. On a wrap the block emits a trailer word that carries a fixed marker and a CRC-16 over the hit words of the frame just closed. The CRC then restarts for the next frame. A turn without hits still yields a trailer, so downstream logic sees exactly one trailer per counter turn.

Top module: `cfmt_top`

## Requirements
- R1: After synchronous reset, `out_valid` is low and `hit_ready` is high while no wrap is present.
- R2: An accepted hit appears on `out_word` as bits [31:23] column address, [22:17] pixel index, [16:7] coarse timestamp, [6:0] fine timestamp, with `out_valid` high from the clock edge that accepts the hit.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` does not change.
- R4: Each wrap pulse produces exactly one trailer word, after every hit accepted before the wrap and before every hit accepted after it; the trailer holds 16'hA5C3 in bits [31:16].
- R5: Trailer bits [15:0] are the CRC of the frame's hit words with polynomial x^16+x^15+x^2+1 (0x8005), register cleared to 0x0000 at frame start, each word fed bit 31 first, with no final inversion.
- R6: A frame with no hits yields a trailer whose CRC field is 0x0000.
- R7: A wrap that arrives while the output register is full and stalled is held; no hit is accepted until the trailer has been loaded.
- R8: In the cycle a wrap pulse is present, `hit_ready` is low, so a hit offered then belongs to the following frame.
- R9: `hit_ready` is low whenever `out_valid` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit taken when high together with `hit_valid` |
| hit_col | input | 9 | Column address |
| hit_pix | input | 6 | Pixel index, 0 to 44 |
| hit_coarse | input | 10 | Coarse timestamp |
| hit_fine | input | 7 | Fine timestamp |
| wrap | input | 1 | One-cycle pulse when the coarse counter completes a turn |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_word | output | 32 | Hit word or trailer word |

## Verification
A hit taken at a rising edge is on `out_word` right after that edge, and a trailer is loaded at the first edge where the output register is free while a wrap is present or pending, so each result is due one register stage after its cause. The bench drives inputs at the falling edge and samples all outputs shortly after it, records each expected word in a scoreboard queue at the moment its hit or wrap is accepted, and pops and compares whenever a handshake completes on the output. Ready-side checks (R7, R8, R9) are made in the same cycle as the stimulus, and the hold check (R3) compares the word in the cycle after a stall.

// File: rtl/cfmt_pkg.sv
package cfmt_pkg;

    localparam int COL_W     = 9;
    localparam int PIX_W     = 6;
    localparam int CRS_W     = 10;
    localparam int FIN_W     = 7;
    localparam int WORD_W    = COL_W + PIX_W + CRS_W + FIN_W;
    localparam int CRC_W     = 16;
    localparam int TAG_W     = WORD_W - CRC_W;
    localparam int NUM_PIX   = 45;

    localparam logic [CRC_W-1:0] CRC_POLY    = 16'h8005;
    localparam logic [TAG_W-1:0] TRAILER_TAG = 16'hA5C3;

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [PIX_W-1:0] pix;
        logic [CRS_W-1:0] coarse;
        logic [FIN_W-1:0] fine;
    } hit_word_t;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [CRC_W-1:0] crc;
    } trailer_word_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_HIT,
        SRC_TRAILER
    } word_src_e;

    // One 32-bit word folded into the CRC register, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                 input logic [WORD_W-1:0] data);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = cur;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ data[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/cfmt_hit_packer.sv
module cfmt_hit_packer
    import cfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [COL_W-1:0]  col,
    input  logic [PIX_W-1:0]  pix,
    input  logic [CRS_W-1:0]  coarse,
    input  logic [FIN_W-1:0]  fine,
    output logic [WORD_W-1:0] word
);

    hit_word_t packed_hit;

    always_comb begin
        packed_hit.col    = col;
        packed_hit.pix    = pix;
        packed_hit.coarse = coarse;
        packed_hit.fine   = fine;
        word              = packed_hit;
    end

    // Upstream contract: only pixels that exist in the column are sent.
    AST_PIX_IN_COLUMN: assert property (@(posedge clk) disable iff (rst)
        take |-> (int'(pix) < NUM_PIX)) else $error("pixel index out of range"); // R2

endmodule

// File: rtl/cfmt_crc_accum.sv
module cfmt_crc_accum
    import cfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fold,
    input  logic [WORD_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= '0;
        end else if (fold) begin
            crc_q <= crc_fold(crc_q, data);
        end
    end

    assign crc = crc_q;

    AST_NO_CLEAR_AND_FOLD: assert property (@(posedge clk) disable iff (rst)
        !(clear && fold)) else $error("trailer and hit loaded together"); // R4

endmodule

// File: rtl/cfmt_out_stage.sv
module cfmt_out_stage
    import cfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_src_e         src,
    input  logic [WORD_W-1:0] din,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              can_load
);

    logic              valid_q;
    logic [WORD_W-1:0] word_q;

    assign can_load = !valid_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= '0;
        end else if (can_load) begin
            valid_q <= (src != SRC_NONE);
            if (src != SRC_NONE) word_q <= din;
        end
    end

    assign out_valid = valid_q;
    assign out_word  = word_q;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)))
        else $error("output changed while stalled"); // R3

endmodule

// File: rtl/cfmt_top.sv
module cfmt_top
    import cfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_valid,
    output logic              hit_ready,
    input  logic [COL_W-1:0]  hit_col,
    input  logic [PIX_W-1:0]  hit_pix,
    input  logic [CRS_W-1:0]  hit_coarse,
    input  logic [FIN_W-1:0]  hit_fine,
    input  logic              wrap,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);

    logic              wrap_pend_q;
    logic              wrap_due;
    logic              can_load;
    logic              load_trailer;
    logic              take_hit;
    logic [WORD_W-1:0] hit_word;
    logic [CRC_W-1:0]  frame_crc;
    trailer_word_t     trailer;
    word_src_e         src;
    logic [WORD_W-1:0] next_word;

    // A wrap seen now or held from a stalled cycle closes the frame first.
    assign wrap_due     = wrap || wrap_pend_q;
    assign load_trailer = can_load && wrap_due;
    assign hit_ready    = can_load && !wrap_due;
    assign take_hit     = hit_valid && hit_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wrap_pend_q <= 1'b0;
        end else if (load_trailer) begin
            wrap_pend_q <= 1'b0;
        end else if (wrap) begin
            wrap_pend_q <= 1'b1;
        end
    end

    cfmt_hit_packer u_pack (
        .clk    (clk),
        .rst    (rst),
        .take   (take_hit),
        .col    (hit_col),
        .pix    (hit_pix),
        .coarse (hit_coarse),
        .fine   (hit_fine),
        .word   (hit_word)
    );

    cfmt_crc_accum u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (load_trailer),
        .fold  (take_hit),
        .data  (hit_word),
        .crc   (frame_crc)
    );

    always_comb begin
        trailer.tag = TRAILER_TAG;
        trailer.crc = frame_crc;
        if (load_trailer) begin
            src       = SRC_TRAILER;
            next_word = trailer;
        end else if (take_hit) begin
            src       = SRC_HIT;
            next_word = hit_word;
        end else begin
            src       = SRC_NONE;
            next_word = hit_word;
        end
    end

    cfmt_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .src       (src),
        .din       (next_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .can_load  (can_load)
    );

    AST_WRAP_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
        wrap |-> !hit_ready) else $error("hit accepted with wrap"); // R8

    AST_FULL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !hit_ready) else $error("hit accepted while stalled"); // R9

    AST_TRAILER_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wrap_due && (!out_valid || out_ready)) |=> (out_valid && out_word[WORD_W-1:CRC_W] == TRAILER_TAG))
        else $error("trailer not loaded"); // R4

    AST_PEND_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
        wrap_pend_q |-> !hit_ready) else $error("hit passed a pending wrap"); // R7

endmodule

// File: tb/cfmt_top_tb_top.sv
module cfmt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [8:0]  hit_col = '0;
    logic [5:0]  hit_pix = '0;
    logic [9:0]  hit_coarse = '0;
    logic [6:0]  hit_fine = '0;
    logic        wrap = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] exp_w[$];
    bit          exp_trl[$];
    bit          fbits[$];
    bit          prev_stall = 0;
    logic [31:0] prev_word = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    cfmt_top dut_i (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_col(hit_col), .hit_pix(hit_pix), .hit_coarse(hit_coarse),
        .hit_fine(hit_fine), .wrap(wrap), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Remainder of (frame bits * x^16) divided by x^16+x^15+x^2+1.
    function automatic logic [15:0] model_crc();
        logic [16:0] rem = '0;
        for (int i = 0; i < fbits.size() + 16; i++) begin
            rem = {rem[15:0], (i < fbits.size()) ? fbits[i] : 1'b0};
            if (rem[16]) rem = rem ^ 17'h18005;
        end
        return rem[15:0];
    endfunction

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Inputs are already set (at the falling edge); sample, then advance one cycle.
    task automatic step();
        logic [31:0] w;
        logic [31:0] e;
        bit          is_trl;
        bit          took;
        #1;
        if (prev_stall) check(out_valid && out_word == prev_word, "R3 hold", out_word, prev_word);
        if (out_valid && !out_ready) check(!hit_ready, "R9 ready", 32'(hit_ready), 32'd0);
        if (wrap) check(!hit_ready, "R8 wrap", 32'(hit_ready), 32'd0);
        if (out_valid && out_ready) begin
            if (exp_w.size() == 0) begin
                check(0, "R4 extra word", out_word, 32'hx);
            end else begin
                e = exp_w.pop_front();
                is_trl = exp_trl.pop_front();
                check(out_word == e, is_trl ? "R5 trailer" : "R2 hit word", out_word, e);
            end
        end
        took = hit_valid && hit_ready;
        if (took) begin
            w = {hit_col, hit_pix, hit_coarse, hit_fine};
            exp_w.push_back(w);
            exp_trl.push_back(0);
            for (int b = 31; b >= 0; b--) fbits.push_back(w[b]);
        end
        if (wrap) begin
            exp_w.push_back({16'hA5C3, model_crc()});
            exp_trl.push_back(1);
            fbits.delete();
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = out_word;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (took) hit_valid = 1'b0;
        wrap = 1'b0;
    endtask

    task automatic offer_hit();
        lfsr = lfsr_next(lfsr);
        hit_col    = lfsr[8:0];
        hit_pix    = 6'(lfsr % 45);
        lfsr = lfsr_next(lfsr);
        hit_coarse = lfsr[9:0];
        hit_fine   = lfsr[15:9];
        hit_valid  = 1'b1;
    endtask

    // Mixed traffic: ready pattern and hit offers from the LFSR, wrap every period.
    task automatic run(input int n, input int period, input bit stall_mode);
        for (int i = 0; i < n; i++) begin
            if (!hit_valid && lfsr[3]) offer_hit();
            else lfsr = lfsr_next(lfsr);
            out_ready = stall_mode ? lfsr[5] | lfsr[7] : 1'b1;
            wrap = (i % period) == period - 1;
            step();
        end
    endtask

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        #1;
        check(!out_valid, "R1 out_valid", 32'(out_valid), 32'd0);
        check(hit_ready, "R1 hit_ready", 32'(hit_ready), 32'd1);
        step();

        // Back-to-back hits then a wrap with free output (R2, R4, R5).
        out_ready = 1'b1;
        for (int i = 0; i < 5; i++) begin
            offer_hit();
            step();
        end
        wrap = 1'b1;
        step();
        step();

        // Two wraps with nothing between: empty frame (R6).
        wrap = 1'b1;
        step();
        #1;
        check(out_valid && out_word == 32'hA5C30000, "R6 empty frame", out_word, 32'hA5C30000);
        step();

        // Hit offered in the same cycle as a wrap (R8).
        offer_hit();
        step();
        offer_hit();
        wrap = 1'b1;
        step();
        step();
        step();

        // Wrap while the output is full and stalled (R7).
        out_ready = 1'b0;
        offer_hit();
        step();
        wrap = 1'b1;
        offer_hit();
        step();
        step();
        out_ready = 1'b1;
        #1;
        check(!hit_ready, "R7 pending wrap", 32'(hit_ready), 32'd0);
        step();
        step();
        step();

        // Random traffic with stalls and periodic wraps.
        run(300, 37, 1);
        run(200, 23, 0);
        run(300, 50, 1);

        // Close the last frame and drain.
        hit_valid = 1'b0;
        out_ready = 1'b1;
        wrap = 1'b1;
        step();
        repeat (4) step();
        check(exp_w.size() == 0, "R4 all words delivered", 32'(exp_w.size()), 32'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<200000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule